// File: doc/BRIEF.md
# Flyback Protection and Soft-Start Mode Controller

This block is the operating-mode state machine of a fixed-frequency flyback controller. It works only on digital flags produced by the analog front end: the supply start, supply-off and supply-reset events, line brownout, die over-temperature, supply overvoltage, the current-limit and maximum-duty indications of the pulse loop, the hard current-stop comparator, the light-load skip comparators, and the two comparators of a window latch pin. From these it decides whether the power switch may be driven. It also produces the stepped soft-start current ceiling and a request to double the NTC bias current.

After a start request the controller ramps a 4-bit ceiling from 1 to 15, one level per step period. A downstream comparator uses the lower of this ceiling and the feedback demand. A sustained overload or a hard current-stop trip ends switching. Depending on a build parameter, the block then either waits out a retry period and restarts through soft-start, or locks off. The latch pin is a window input with separately blanked upper and lower edges. The upper edge is armed as soon as the block leaves Stopped. The lower edge is only armed once soft-start has ended. All timers count pulses of a supplied time base `tick`, so one design serves any clock rate.

Top module: `flyback_mode_ctrl`

## Requirements
- R1: Mode codes are Stopped=0, Soft-start=1, Running=2, Skip=3, Fault=4, Latch=5. While reset is held the block shows mode 0, drive off, ceiling 0 and no NTC boost.
- R2: In Stopped, start_req moves the block to Soft-start at the next clock edge. It enters with ceiling 1 and drive on. ntc_boost is high in Soft-start and in no other mode.
- R3: In Soft-start the ceiling rises by one after every SS_STEP ticks. When level 15 has been held for SS_STEP ticks the block enters Running. The ceiling is 15 in Running and Skip and 0 in Stopped, Fault and Latch.
- R4: In Soft-start or Running, a fault timer counts ticks while at_limit or dmax_end is high. On the tick that completes FAULT_LONG ticks (FAULT_SHORT when SHORT_OPT=1) the overload action is taken. Any cycle with both flags low clears the timer.
- R5: cs_stop in Soft-start or Running takes the overload action at the next edge, with no timer.
- R6: The overload action is Fault when AUTO_RETRY=1 and Latch when AUTO_RETRY=0. Fault counts RETRY_LONG ticks (RETRY_SHORT when SHORT_OPT=1) and then restarts in Soft-start. With tick low no timer advances.
- R7: Running with skip_in goes to Skip. Skip with skip_out returns to Running. skip_in has no effect in Soft-start.
- R8: vcc_ovp in any mode other than Latch goes to Latch. latch_hi held for HI_BLANK ticks in Soft-start, Running, Skip or Fault goes to Latch. latch_lo held for LO_BLANK ticks in Running, Skip or Fault goes to Latch. latch_lo is ignored in Soft-start, and its blanking count restarts once soft-start ends.
- R9: Latch is left only by brownout or vcc_reset, which go to Stopped. tsd, vcc_off and start_req do not release it.
- R10: In any mode other than Latch, brownout, tsd, vcc_off or vcc_reset goes to Stopped. This takes priority over every other condition.
- R11: drive_en is high exactly in Soft-start and Running. It falls in the same cycle as the mode changes to Fault, Latch, Skip or Stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base pulse that advances all timers |
| start_req | input | 1 | Supply reached its turn-on level |
| brownout | input | 1 | Line voltage too low |
| tsd | input | 1 | Die over-temperature |
| vcc_off | input | 1 | Supply fell below its turn-off level |
| vcc_reset | input | 1 | Supply fell to the logic reset level |
| vcc_ovp | input | 1 | Supply overvoltage |
| at_limit | input | 1 | Current ceiling sits at its maximum |
| dmax_end | input | 1 | Pulse was ended by maximum duty |
| cs_stop | input | 1 | Hard current-stop comparator tripped |
| skip_in | input | 1 | Feedback fell below the skip entry level |
| skip_out | input | 1 | Feedback rose above the skip exit level |
| latch_hi | input | 1 | Latch pin above its upper threshold |
| latch_lo | input | 1 | Latch pin below its lower threshold |
| drive_en | output | 1 | Switching permitted |
| ss_level | output | 4 | Soft-start current ceiling, 0 to 15 |
| ntc_boost | output | 1 | Request doubled NTC bias current |
| mode | output | 3 | Current mode code |

## Verification
A wrong mode register is visible on `mode` and `drive_en` one edge after the offending input, because every output decodes straight from state. A wrong timer or blanking count shifts the edge at which the mode changes by whole ticks. The stimulus therefore holds each condition for one tick short of its limit and checks that nothing happens, then checks the change on the very next edge. A ramp error shows as a wrong `ss_level` in a specific cycle of the 30-step ramp, and every cycle of that ramp is compared.

// File: rtl/flyback_mode_ctrl.sv
module flyback_mode_ctrl #(
  parameter bit AUTO_RETRY  = 1'b1,
  parameter bit SHORT_OPT   = 1'b0,
  parameter int FAULT_LONG  = 12800,
  parameter int FAULT_SHORT = 3200,
  parameter int RETRY_LONG  = 100000,
  parameter int RETRY_SHORT = 150000,
  parameter int SS_STEP     = 27,
  parameter int HI_BLANK    = 5,
  parameter int LO_BLANK    = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_req,
  input  logic       brownout,
  input  logic       tsd,
  input  logic       vcc_off,
  input  logic       vcc_reset,
  input  logic       vcc_ovp,
  input  logic       at_limit,
  input  logic       dmax_end,
  input  logic       cs_stop,
  input  logic       skip_in,
  input  logic       skip_out,
  input  logic       latch_hi,
  input  logic       latch_lo,
  output logic       drive_en,
  output logic [3:0] ss_level,
  output logic       ntc_boost,
  output logic [2:0] mode
);

  localparam int FAULT_N = SHORT_OPT ? FAULT_SHORT : FAULT_LONG;
  localparam int RETRY_N = SHORT_OPT ? RETRY_SHORT : RETRY_LONG;

  localparam int FW = (FAULT_N  > 1) ? $clog2(FAULT_N)  : 1;
  localparam int RW = (RETRY_N  > 1) ? $clog2(RETRY_N)  : 1;
  localparam int SW = (SS_STEP  > 1) ? $clog2(SS_STEP)  : 1;
  localparam int HW = (HI_BLANK > 1) ? $clog2(HI_BLANK) : 1;
  localparam int LW = (LO_BLANK > 1) ? $clog2(LO_BLANK) : 1;

  localparam logic [FW-1:0] F_LAST = FW'(FAULT_N - 1);
  localparam logic [RW-1:0] R_LAST = RW'(RETRY_N - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SS_STEP - 1);
  localparam logic [HW-1:0] H_LAST = HW'(HI_BLANK - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LO_BLANK - 1);

  localparam logic [2:0] ST_STOP  = 3'd0;
  localparam logic [2:0] ST_SOFT  = 3'd1;
  localparam logic [2:0] ST_RUN   = 3'd2;
  localparam logic [2:0] ST_SKIP  = 3'd3;
  localparam logic [2:0] ST_FAULT = 3'd4;
  localparam logic [2:0] ST_LATCH = 3'd5;

  localparam logic [2:0] ST_OVLD = AUTO_RETRY ? ST_FAULT : ST_LATCH;
  localparam logic [3:0] LVL_TOP = 4'd15;

  logic [2:0]    st, st_nx;
  logic [3:0]    lvl, lvl_nx;
  logic [FW-1:0] f_cnt;
  logic [RW-1:0] r_cnt;
  logic [SW-1:0] s_cnt;
  logic [HW-1:0] h_cnt;
  logic [LW-1:0] l_cnt;

  wire kill     = brownout | tsd | vcc_off | vcc_reset;
  wire driving  = (st == ST_SOFT) || (st == ST_RUN);
  wire hi_armed = (st == ST_SOFT) || (st == ST_RUN) || (st == ST_SKIP) || (st == ST_FAULT);
  wire lo_armed = (st == ST_RUN) || (st == ST_SKIP) || (st == ST_FAULT);

  wire f_run   = driving && (at_limit || dmax_end);
  wire f_exp   = f_run && tick && (f_cnt == F_LAST);
  wire r_exp   = (st == ST_FAULT) && tick && (r_cnt == R_LAST);
  wire s_exp   = (st == ST_SOFT) && tick && (s_cnt == S_LAST);
  wire hi_hold = hi_armed && latch_hi;
  wire lo_hold = lo_armed && latch_lo;
  wire hi_trip = hi_hold && tick && (h_cnt == H_LAST);
  wire lo_trip = lo_hold && tick && (l_cnt == L_LAST);

  always_comb begin
    st_nx = st;
    if (st == ST_LATCH) begin
      if (brownout || vcc_reset) st_nx = ST_STOP;
    end else if (kill) begin
      st_nx = ST_STOP;
    end else if (vcc_ovp || hi_trip || lo_trip) begin
      st_nx = ST_LATCH;
    end else if (driving && (cs_stop || f_exp)) begin
      st_nx = ST_OVLD;
    end else begin
      case (st)
        ST_STOP:  if (start_req) st_nx = ST_SOFT;
        ST_SOFT:  if (s_exp && lvl == LVL_TOP) st_nx = ST_RUN;
        ST_RUN:   if (skip_in) st_nx = ST_SKIP;
        ST_SKIP:  if (skip_out) st_nx = ST_RUN;
        ST_FAULT: if (r_exp) st_nx = ST_SOFT;
        default:  st_nx = ST_STOP;
      endcase
    end
  end

  always_comb begin
    case (st_nx)
      ST_SOFT: begin
        if (st != ST_SOFT) lvl_nx = 4'd1;
        else if (s_exp)    lvl_nx = lvl + 4'd1;
        else               lvl_nx = lvl;
      end
      ST_RUN, ST_SKIP: lvl_nx = LVL_TOP;
      default:         lvl_nx = 4'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_STOP;
      lvl <= 4'd0;
    end else begin
      st  <= st_nx;
      lvl <= lvl_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        f_cnt <= '0;
    else if (!f_run)                   f_cnt <= '0;
    else if (tick && f_cnt != F_LAST)  f_cnt <= f_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    r_cnt <= '0;
    else if (st != ST_FAULT || st_nx != ST_FAULT)  r_cnt <= '0;
    else if (tick)                                 r_cnt <= r_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  s_cnt <= '0;
    else if (st != ST_SOFT || st_nx != ST_SOFT)  s_cnt <= '0;
    else if (s_exp)                              s_cnt <= '0;
    else if (tick)                               s_cnt <= s_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        h_cnt <= '0;
    else if (!hi_hold)                 h_cnt <= '0;
    else if (tick && h_cnt != H_LAST)  h_cnt <= h_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        l_cnt <= '0;
    else if (!lo_hold)                 l_cnt <= '0;
    else if (tick && l_cnt != L_LAST)  l_cnt <= l_cnt + 1'b1;
  end

  assign drive_en  = driving;
  assign ss_level  = lvl;
  assign ntc_boost = (st == ST_SOFT);
  assign mode      = st;

endmodule

// File: rtl/flyback_mode_ctrl_chk.sv
module flyback_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       brownout,
  input logic       tsd,
  input logic       vcc_off,
  input logic       vcc_reset,
  input logic       vcc_ovp,
  input logic       cs_stop,
  input logic       skip_in,
  input logic       skip_out,
  input logic       drive_en,
  input logic [3:0] ss_level,
  input logic [2:0] mode
);

  wire kill = brownout | tsd | vcc_off | vcc_reset;

  AST_SOFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && start_req && !kill && !vcc_ovp) |=> (mode == 3'd1 && ss_level == 4'd1 && drive_en)); // R2

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) ##1 (mode == 3'd1) |-> (ss_level == $past(ss_level) || ss_level == $past(ss_level) + 4'd1)); // R3

  AST_CS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd1 || mode == 3'd2) && cs_stop && !kill) |=> (!drive_en && (mode == 3'd4 || mode == 3'd5))); // R5

  AST_SKIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && skip_in && !kill) |=> (!drive_en && (mode == 3'd3 || mode == 3'd4 || mode == 3'd5))); // R7

  AST_SKIP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && skip_out && !kill) |=> (mode == 3'd2 || mode == 3'd5)); // R7

  AST_OVP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd5 && vcc_ovp && !kill) |=> (mode == 3'd5 && !drive_en)); // R8

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !brownout && !vcc_reset) |=> (mode == 3'd5)); // R9

  AST_LATCH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && (brownout || vcc_reset)) |=> (mode == 3'd0)); // R9

  AST_KILL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd5 && kill) |=> (mode == 3'd0 && !drive_en && ss_level == 4'd0)); // R10

endmodule

bind flyback_mode_ctrl flyback_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .brownout(brownout), .tsd(tsd),
  .vcc_off(vcc_off), .vcc_reset(vcc_reset), .vcc_ovp(vcc_ovp), .cs_stop(cs_stop),
  .skip_in(skip_in), .skip_out(skip_out), .drive_en(drive_en), .ss_level(ss_level), .mode(mode)
);

// File: tb/tb_flyback_mode_ctrl.sv
module tb_flyback_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  localparam logic [12:0] NONE = 13'h0000, STA = 13'h1000, BOT = 13'h0800, TSD = 13'h0400,
                          VOF = 13'h0200, VRS = 13'h0100, OVP = 13'h0080, LIM = 13'h0040,
                          DMX = 13'h0020, CSS = 13'h0010, SKI = 13'h0008, SKO = 13'h0004,
                          LHI = 13'h0002, LLO = 13'h0001;

  localparam int NV = 27;
  // row: {inputs, cycles, expected mode, expected drive}
  localparam logic [24:0] VEC [NV] = '{
    {NONE, 8'd1,  3'd0, 1'b0},          // R1 idle
    {STA,  8'd1,  3'd1, 1'b1},          // R2 start
    {LLO,  8'd10, 3'd1, 1'b1},          // R8 low edge ignored in soft-start
    {NONE, 8'd19, 3'd1, 1'b1},          // R3
    {NONE, 8'd1,  3'd2, 1'b1},          // R3 ramp done
    {LIM,  8'd5,  3'd2, 1'b1},          // R4 one short
    {NONE, 8'd1,  3'd2, 1'b1},          // R4 clear
    {DMX,  8'd5,  3'd2, 1'b1},          // R4 restarted count
    {DMX,  8'd1,  3'd4, 1'b0},          // R4 R6 R11
    {NONE, 8'd7,  3'd4, 1'b0},          // R6 waiting
    {NONE, 8'd1,  3'd1, 1'b1},          // R6 retry
    {SKI,  8'd3,  3'd1, 1'b1},          // R7 skip ignored in soft-start
    {NONE, 8'd26, 3'd1, 1'b1},          // R3
    {NONE, 8'd1,  3'd2, 1'b1},          // R3
    {SKI,  8'd1,  3'd3, 1'b0},          // R7 R11
    {NONE, 8'd2,  3'd3, 1'b0},          // R7
    {SKO,  8'd1,  3'd2, 1'b1},          // R7
    {LHI,  8'd2,  3'd2, 1'b1},          // R8 blanked
    {LHI,  8'd1,  3'd5, 1'b0},          // R8
    {TSD | VOF | STA, 8'd1, 3'd5, 1'b0},// R9 no release
    {BOT,  8'd1,  3'd0, 1'b0},          // R9 release
    {STA,  8'd1,  3'd1, 1'b1},          // R2
    {OVP,  8'd1,  3'd5, 1'b0},          // R8
    {VRS,  8'd1,  3'd0, 1'b0},          // R9
    {STA,  8'd1,  3'd1, 1'b1},          // R2
    {TSD,  8'd1,  3'd0, 1'b0},          // R10
    {STA | BOT, 8'd1, 3'd0, 1'b0}       // R10 priority
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic start_req, brownout, tsd, vcc_off, vcc_reset, vcc_ovp, at_limit, dmax_end;
  logic cs_stop, skip_in, skip_out, latch_hi, latch_lo;
  logic       drv_a, ntc_a, drv_l, ntc_l;
  logic [3:0] lvl_a, lvl_l;
  logic [2:0] mode_a, mode_l;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyback_mode_ctrl #(.AUTO_RETRY(1'b1), .SHORT_OPT(1'b0), .FAULT_LONG(6), .FAULT_SHORT(3),
    .RETRY_LONG(8), .RETRY_SHORT(12), .SS_STEP(2), .HI_BLANK(3), .LO_BLANK(5)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req), .brownout(brownout),
    .tsd(tsd), .vcc_off(vcc_off), .vcc_reset(vcc_reset), .vcc_ovp(vcc_ovp),
    .at_limit(at_limit), .dmax_end(dmax_end), .cs_stop(cs_stop), .skip_in(skip_in),
    .skip_out(skip_out), .latch_hi(latch_hi), .latch_lo(latch_lo),
    .drive_en(drv_a), .ss_level(lvl_a), .ntc_boost(ntc_a), .mode(mode_a));

  flyback_mode_ctrl #(.AUTO_RETRY(1'b0), .SHORT_OPT(1'b0), .FAULT_LONG(6), .FAULT_SHORT(3),
    .RETRY_LONG(8), .RETRY_SHORT(12), .SS_STEP(2), .HI_BLANK(3), .LO_BLANK(5)) dut_lat (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req), .brownout(brownout),
    .tsd(tsd), .vcc_off(vcc_off), .vcc_reset(vcc_reset), .vcc_ovp(vcc_ovp),
    .at_limit(at_limit), .dmax_end(dmax_end), .cs_stop(cs_stop), .skip_in(skip_in),
    .skip_out(skip_out), .latch_hi(latch_hi), .latch_lo(latch_lo),
    .drive_en(drv_l), .ss_level(lvl_l), .ntc_boost(ntc_l), .mode(mode_l));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [12:0] v);
    {start_req, brownout, tsd, vcc_off, vcc_reset, vcc_ovp, at_limit, dmax_end,
     cs_stop, skip_in, skip_out, latch_hi, latch_lo} = v;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick  = 1'b1;
    set_in(NONE);
    step(2);
    chk("R1 reset mode", mode_a, 0);
    chk("R1 reset drive", drv_a, 0);
    chk("R1 reset level", lvl_a, 0);
    chk("R1 reset boost", ntc_a, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [24:0] row;
      row = VEC[i];
      set_in(row[24:12]);
      step(int'(row[11:4]));
      chk($sformatf("R2-table row %0d mode", i), mode_a, int'(row[3:1]));
      chk($sformatf("R11 table row %0d drive", i), drv_a, int'(row[0]));
    end

    // R3 ramp, cycle by cycle, and R2 NTC boost
    do_reset();
    set_in(STA); step(1); set_in(NONE);
    for (int k = 0; k < 30; k++) begin
      chk("R3 ramp level", lvl_a, (1 + k / 2 > 15) ? 15 : 1 + k / 2);
      chk("R2 boost in soft-start", ntc_a, 1);
      step(1);
    end
    chk("R3 running mode", mode_a, 2);
    chk("R3 running level", lvl_a, 15);
    chk("R2 boost off in running", ntc_a, 0);

    // R8 low edge armed after soft-start
    set_in(LLO); step(4);
    chk("R8 low edge blanked", mode_a, 2);
    step(1);
    chk("R8 low edge latches", mode_a, 5);
    chk("R3 level zero in latch", lvl_a, 0);

    // R5 R6 current-stop, both options
    do_reset();
    set_in(STA); step(1);
    set_in(CSS); step(1); set_in(NONE);
    chk("R5 R6 cs stop auto-retry", mode_a, 4);
    chk("R5 R6 cs stop latched", mode_l, 5);
    chk("R11 drive off latched", drv_l, 0);

    // R4 R6 overload timer, latched option
    do_reset();
    set_in(STA); step(1);
    set_in(LIM); step(5);
    chk("R4 timer not yet", mode_l, 1);
    step(1); set_in(NONE);
    chk("R4 R6 timer latched", mode_l, 5);
    chk("R4 R6 timer auto-retry", mode_a, 4);

    // R6 tick gating of retry timer
    tick = 1'b0; step(20);
    chk("R6 frozen without tick", mode_a, 4);
    tick = 1'b1; step(7);
    chk("R6 retry not yet", mode_a, 4);
    step(1);
    chk("R6 retry restarts soft-start", mode_a, 1);

    // R8 high edge armed in soft-start; R9 latched copy holds
    set_in(LHI); step(3);
    chk("R8 high edge in soft-start", mode_a, 5);
    set_in(VOF); step(1);
    chk("R9 vcc_off no release", mode_l, 5);
    set_in(BOT); step(1); set_in(NONE);
    chk("R9 brownout release", mode_l, 0);
    chk("R9 brownout release auto", mode_a, 0);

    // R10 supply-off from Fault
    do_reset();
    set_in(STA); step(1);
    set_in(CSS); step(1);
    set_in(VOF); step(1); set_in(NONE);
    chk("R10 vcc_off from fault", mode_a, 0);
    chk("R10 drive off", drv_a, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule